// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error Flags

This block receives characters from an asynchronous serial line that idles high. Its clock runs at the sampling rate, and one clock cycle is one line sample. A run-time programmable number of samples makes up one bit. A falling edge on the line starts a candidate start bit. The candidate is accepted only if the line stays low until the middle of that bit. From that point the block takes one sample per bit period, so every later sample falls at the centre of its bit. The data bits arrive least significant bit first. An optional parity bit follows them, and a single stop bit ends the character.

Each completed character ends in one of two ways. If it is good, it is loaded into a holding register and a valid flag is raised. Otherwise a framing error flag, a parity error flag, or both are raised. All flags stay set until the consumer pulses an acknowledge. The holding register keeps the last good character while the next one is shifted in. A good character that completes while the valid flag is still set raises an overrun flag and replaces the held character. A line that stays low for longer than a whole character raises a break indication.

The bit period is written into a pending register at any time. It reaches the active register only while the receiver is idle and the line is high.

Top module: `uart_rx_ovs`

## Requirements
- R1: After reset, valid_o, frame_err_o, parity_err_o, overrun_o and break_o are 0, and data_o is 0.
- R2: rx_i passes through a two-stage synchronizer. A falling edge starts qualification. A low pulse of at most L>>1 samples is discarded, where L is the active bit length. A low pulse of (L>>1)+1 samples or more is accepted as a start bit.
- R3: After a start bit is accepted, bits are sampled every L cycles, starting L cycles after qualification. The 8 data bits are taken least significant first. When the stop bit is sampled high and parity passes, data_o is loaded and valid_o rises. This happens 3+(L>>1)+(F-1)*L cycles after the start bit first appears on rx_i, where F is the number of bits in the frame.
- R4: valid_o and every error flag stay set until a cycle with ack_i high. That cycle clears them, unless the same cycle sets the flag again.
- R5: A stop bit sampled low sets frame_err_o. In that case valid_o is not set and data_o keeps its previous value.
- R6: When par_en_i=1, a parity bit follows the MSB and F = 11; otherwise F = 10. With par_odd_i=1, the total count of ones over the data and parity bits must be odd; with par_odd_i=0 it must be even. A mismatch sets parity_err_o and suppresses valid_o.
- R7: break_o is high while the synchronized line has been low for more than F*L consecutive samples. It drops one cycle after the synchronized line returns high.
- R8: A good character that completes while valid_o is set, with no ack_i in that cycle, sets overrun_o. data_o then takes the newer character.
- R9: cfg_we_i loads cfg_len_i into a pending register. The active bit length takes the pending value only in cycles where the receiver is idle and the synchronized line is high. A write during a reception, or during the cycle where a start edge is seen, does not affect the character being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| cfg_we_i | input | 1 | Write strobe for the pending bit length |
| cfg_len_i | input | CW | Samples per bit, at least 2 |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| ack_i | input | 1 | Consumer acknowledge; clears the flags |
| data_o | output | DW | Last good character |
| valid_o | output | 1 | Unacknowledged good character held |
| frame_err_o | output | 1 | Stop bit was low |
| parity_err_o | output | 1 | Parity mismatch |
| overrun_o | output | 1 | Held character was overwritten |
| break_o | output | 1 | Line low for longer than one character |

## Verification
The hardest case is the rate-change lockout at the moment a start bit appears. A new bit length written one cycle after the start bit is driven reaches the pending register just as the receiver is still idle but now sees the line low. Only the line-low term of the transfer condition keeps the active rate unchanged in that cycle. The bench forks the rate write so that it lands in exactly that cycle, next to a frame sent at the old rate. It then checks that the frame still decodes at the old timing and that the next frame decodes at the new one. The other corners are also checked: the one-sample boundary of start qualification (a pulse of L>>1 samples is rejected, one sample longer decodes as 0xFF), overrun on back-to-back characters, and a low line that first yields a framing error and then a break.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic line_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], rx_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign line_o = sh_q[STAGES-1];
  assign fall_o = prev_q & ~line_o;
endmodule

// File: rtl/uart_rx_rate.sv
module uart_rx_rate #(
  parameter int CW      = 8,
  parameter int DEF_LEN = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [CW-1:0] len_i,
  input  logic          allow_i,
  output logic [CW-1:0] len_o
);
  logic [CW-1:0] pend_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= CW'(DEF_LEN);
      act_q  <= CW'(DEF_LEN);
    end else begin
      if (we_i)    pend_q <= len_i;
      if (allow_i) act_q  <= pend_q;
    end
  end

  assign len_o = act_q;
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk #(
  parameter int TW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_i,
  input  logic [TW-1:0] thr_i,
  output logic          brk_o
);
  logic [TW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              run_q <= '0;
    else if (line_i)          run_q <= '0;
    else if (run_q != '1)     run_q <= run_q + TW'(1);
  end

  assign brk_o = run_q > thr_i;

  // R7
  brk_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_o && line_i) |=> !brk_o);
endmodule

// File: rtl/uart_rx_ovs.sv
module uart_rx_ovs
  import uart_rx_pkg::*;
#(
  parameter int DW      = 8,
  parameter int CW      = 8,
  parameter int DEF_LEN = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_i,
  input  logic          cfg_we_i,
  input  logic [CW-1:0] cfg_len_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          ack_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          frame_err_o,
  output logic          parity_err_o,
  output logic          overrun_o,
  output logic          break_o
);
  localparam int IW = $clog2(DW + 2);
  localparam int TW = CW + $clog2(DW + 4);

  logic          line, fall;
  logic [CW-1:0] act_len, half_len;
  logic [TW-1:0] brk_thr;

  rx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q, last_idx;
  logic [DW-1:0] sh_q, data_q;
  logic          par_q;
  logic          valid_q, ferr_q, perr_q, ovr_q;
  logic          bit_end, done, par_bad, good;

  uart_rx_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .rx_i(rx_i), .line_o(line), .fall_o(fall)
  );

  uart_rx_rate #(.CW(CW), .DEF_LEN(DEF_LEN)) u_rate (
    .clk_i  (clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .len_i(cfg_len_i),
    .allow_i(state_q == ST_IDLE && line), .len_o(act_len)
  );

  assign brk_thr = (TW'(DW + 2) + TW'(par_en_i)) * TW'(act_len);

  uart_rx_brk #(.TW(TW)) u_brk (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line), .thr_i(brk_thr), .brk_o(break_o)
  );

  assign half_len = act_len >> 1;
  assign last_idx = par_en_i ? IW'(DW) : IW'(DW - 1);
  assign bit_end  = cnt_q == act_len - CW'(1);
  assign done     = state_q == ST_STOP && bit_end;
  // parity accumulator includes the received parity bit; nonzero means mismatch
  assign par_bad  = par_en_i & par_q;
  assign good     = done & line & ~par_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (fall) begin
            state_q <= ST_START;
            par_q   <= par_odd_i;
          end
        end
        ST_START: begin
          if (line) begin
            state_q <= ST_IDLE;
          end else if (cnt_q == half_len - CW'(1)) begin
            state_q <= ST_DATA;
            cnt_q   <= '0;
            idx_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_DATA: begin
          if (bit_end) begin
            cnt_q <= '0;
            par_q <= par_q ^ line;
            if (idx_q < IW'(DW)) sh_q <= {line, sh_q[DW-1:1]};
            if (idx_q == last_idx) state_q <= ST_STOP;
            else                   idx_q   <= idx_q + IW'(1);
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_STOP: begin
          if (bit_end) state_q <= ST_IDLE;
          else         cnt_q   <= cnt_q + CW'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
      perr_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (good) data_q <= sh_q;
      valid_q <= good                          ? 1'b1 : (ack_i ? 1'b0 : valid_q);
      ferr_q  <= (done && !line)               ? 1'b1 : (ack_i ? 1'b0 : ferr_q);
      perr_q  <= (done && par_bad)             ? 1'b1 : (ack_i ? 1'b0 : perr_q);
      ovr_q   <= (good && valid_q && !ack_i)   ? 1'b1 : (ack_i ? 1'b0 : ovr_q);
    end
  end

  assign data_o       = data_q;
  assign valid_o      = valid_q;
  assign frame_err_o  = ferr_q;
  assign parity_err_o = perr_q;
  assign overrun_o    = ovr_q;

  // R2
  start_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && line) |=> state_q == ST_IDLE);
  // R4
  valid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ack_i) |=> valid_o);
  // R5
  frame_novalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !line) |=> !$rose(valid_o));
  // R8
  overrun_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(valid_o));
  // R9
  rate_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE || !line) |=> $stable(act_len));
endmodule

// File: tb/uart_rx_ovs_bench.sv
module uart_rx_ovs_bench;
  localparam int DW = 8;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx = 1'b1;
  logic          cfg_we = 1'b0;
  logic [CW-1:0] cfg_len = 8'd8;
  logic          par_en = 1'b0;
  logic          par_odd = 1'b0;
  logic          ack = 1'b0;
  logic [DW-1:0] data_o;
  logic          valid_o, ferr_o, perr_o, ovr_o, brk_o;

  always #4 clk = ~clk;

  uart_rx_ovs u_uart_rx_ovs (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .cfg_we_i(cfg_we), .cfg_len_i(cfg_len),
    .par_en_i(par_en), .par_odd_i(par_odd), .ack_i(ack), .data_o(data_o),
    .valid_o(valid_o), .frame_err_o(ferr_o), .parity_err_o(perr_o),
    .overrun_o(ovr_o), .break_o(brk_o)
  );

  int compared = 0, mismatched = 0, cyc = 0;
  bit finished = 0;

  // reference model state
  bit   e_valid, e_ferr, e_perr, e_ovr, e_brk;
  int   e_data;
  int   q_cyc[$], q_dat[$];
  bit   q_fe[$], q_pe[$];
  int   run = 0, m_len = 8;
  bit   h1 = 1, h2 = 1, m_par = 0;

  always @(posedge clk) begin
    bit sv, sf, sp;
    int d;
    cyc++;
    sv = 0; sf = 0; sp = 0; d = 0;
    if (!rst_n) begin
      e_valid = 0; e_ferr = 0; e_perr = 0; e_ovr = 0; e_brk = 0; e_data = 0;
      h1 = 1; h2 = 1; run = 0;
    end else begin
      if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
        void'(q_cyc.pop_front());
        d  = q_dat.pop_front();
        sf = q_fe.pop_front();
        sp = q_pe.pop_front();
        sv = !sf && !sp;
      end
      e_ovr   = (sv && e_valid && !ack) ? 1 : (ack ? 0 : e_ovr);
      e_valid = sv ? 1 : (ack ? 0 : e_valid);
      e_ferr  = sf ? 1 : (ack ? 0 : e_ferr);
      e_perr  = sp ? 1 : (ack ? 0 : e_perr);
      if (sv) e_data = d;
      run   = h2 ? 0 : run + 1;
      e_brk = run > (2 + DW + int'(m_par)) * m_len;
      h2 = h1;
      h1 = rx;
    end
  end

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cmp(32'(valid_o), 32'(e_valid), "R3 valid_o");
      cmp(32'(data_o),  32'(e_data),  "R3 data_o");
      cmp(32'(ferr_o),  32'(e_ferr),  "R5 frame_err_o");
      cmp(32'(perr_o),  32'(e_perr),  "R6 parity_err_o");
      cmp(32'(ovr_o),   32'(e_ovr),   "R8 overrun_o");
      cmp(32'(brk_o),   32'(e_brk),   "R7 break_o");
    end
  end

  task automatic push_ev(input int at, input int d, input bit fe, input bit pe);
    q_cyc.push_back(at); q_dat.push_back(d); q_fe.push_back(fe); q_pe.push_back(pe);
  endtask

  task automatic send(input int d, input int len, input bit flip, input bit stop);
    int fb, c;
    bit p;
    fb = 2 + DW + int'(par_en);
    @(negedge clk);
    c = cyc;
    p = (^d[DW-1:0]) ^ par_odd ^ flip;
    push_ev(c + 3 + len / 2 + (fb - 1) * len, d, !stop, par_en && flip);
    rx = 1'b0;
    repeat (len) @(negedge clk);
    for (int i = 0; i < DW; i++) begin
      rx = d[i];
      repeat (len) @(negedge clk);
    end
    if (par_en) begin
      rx = p;
      repeat (len) @(negedge clk);
    end
    rx = stop;
    repeat (len) @(negedge clk);
    rx = 1'b1;
  endtask

  task automatic pulse(input int n, input bit accept);
    @(negedge clk);
    if (accept) push_ev(cyc + 3 + m_len / 2 + (1 + DW) * m_len, 'hFF, 0, 0);
    rx = 1'b0;
    repeat (n) @(negedge clk);
    rx = 1'b1;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic set_len(input int len);
    @(negedge clk); cfg_we = 1'b1; cfg_len = CW'(len);
    @(negedge clk); cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    m_len = len;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({valid_o, ferr_o, perr_o, ovr_o, brk_o} == 5'b0, "R1 flags", int'({valid_o, ferr_o, perr_o, ovr_o, brk_o}), 0);
    chk(data_o == 0, "R1 data", int'(data_o), 0);

    // R3 basic character
    send('hA5, 8, 0, 1);
    repeat (20) @(negedge clk);
    chk(valid_o && data_o == 8'hA5, "R3 char A5", int'(data_o), 'hA5);
    // R4 acknowledge clears
    repeat (5) @(negedge clk);
    chk(valid_o == 1, "R4 held", int'(valid_o), 1);
    do_ack();
    @(negedge clk);
    chk(valid_o == 0, "R4 cleared", int'(valid_o), 0);

    // R2 boundary: L>>1 rejected, (L>>1)+1 accepted
    pulse(4, 0);
    repeat (100) @(negedge clk);
    chk(valid_o == 0 && ferr_o == 0, "R2 short pulse", int'(valid_o), 0);
    pulse(5, 1);
    repeat (100) @(negedge clk);
    chk(valid_o && data_o == 8'hFF, "R2 long pulse", int'(data_o), 'hFF);
    do_ack();

    // R8 overrun, back-to-back
    send('h3C, 8, 0, 1);
    send('hC3, 8, 0, 1);
    repeat (20) @(negedge clk);
    chk(ovr_o && data_o == 8'hC3, "R8 overrun", int'({ovr_o, data_o}), 'h1C3);
    do_ack();

    // R5 framing error keeps old data
    send('h55, 8, 0, 0);
    repeat (20) @(negedge clk);
    chk(ferr_o && !valid_o && data_o == 8'hC3, "R5 framing", int'({ferr_o, valid_o, data_o}), 'h2C3);
    do_ack();

    // R6 parity, even then odd
    @(negedge clk); par_en = 1; par_odd = 0; m_par = 1;
    send('h96, 8, 0, 1);
    repeat (20) @(negedge clk);
    chk(valid_o && !perr_o && data_o == 8'h96, "R6 even ok", int'(data_o), 'h96);
    do_ack();
    send('h96, 8, 1, 1);
    repeat (20) @(negedge clk);
    chk(perr_o && !valid_o, "R6 even bad", int'({perr_o, valid_o}), 2);
    do_ack();
    @(negedge clk); par_odd = 1;
    send('h01, 8, 0, 1);
    repeat (20) @(negedge clk);
    chk(valid_o && !perr_o && data_o == 8'h01, "R6 odd ok", int'(data_o), 1);
    do_ack();
    send('h01, 8, 1, 1);
    repeat (20) @(negedge clk);
    chk(perr_o && !valid_o, "R6 odd bad", int'({perr_o, valid_o}), 2);
    do_ack();
    @(negedge clk); par_en = 0; par_odd = 0; m_par = 0;
    repeat (5) @(negedge clk);

    // R7 break: long low gives framing error then break
    @(negedge clk);
    push_ev(cyc + 3 + 4 + 9 * 8, 0, 1, 0);
    rx = 1'b0;
    repeat (120) @(negedge clk);
    chk(brk_o && ferr_o, "R7 break raised", int'({brk_o, ferr_o}), 3);
    rx = 1'b1;
    repeat (5) @(negedge clk);
    chk(!brk_o, "R7 break released", int'(brk_o), 0);
    do_ack();
    repeat (5) @(negedge clk);

    // R9 rate write landing as the start edge is seen
    fork
      send('h5A, 8, 0, 1);
      begin
        @(negedge clk); @(negedge clk);
        cfg_we = 1'b1; cfg_len = 8'd12;
        @(negedge clk); cfg_we = 1'b0;
      end
    join
    repeat (20) @(negedge clk);
    chk(valid_o && data_o == 8'h5A, "R9 old rate kept", int'(data_o), 'h5A);
    m_len = 12;
    do_ack();
    send('h81, 12, 0, 1);
    repeat (20) @(negedge clk);
    chk(valid_o && data_o == 8'h81, "R9 new rate", int'(data_o), 'h81);
    do_ack();
    set_len(5);
    send('h6E, 5, 0, 1);
    repeat (20) @(negedge clk);
    chk(valid_o && data_o == 8'h6E, "R9 odd length", int'(data_o), 'h6E);
    do_ack();
    repeat (10) @(negedge clk);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule